// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Borrow-Style Carry

This unit does the data-path arithmetic of a small 8-bit processor. It takes two operands, `a_i` and `b_i`, and a 4-bit operation select, and forms its results combinationally in the same cycle. Each operand may come from a register or from an immediate field; the unit does not care which. One result goes to a destination register and a second goes to the accumulator. The operations are bitwise logic, addition with and without carry, and subtraction in both operand orders with and without carry. There are also decrement, compare, and unsigned and signed multiply. Subtraction treats the carry flag as an inverted borrow. A set carry means no borrow is pending, and an underflow clears it.

Three status flags live in a register inside the unit: carry (C), overflow (V) and zero (Z). On a rising clock edge with `exec_en_i` high, each flag takes its new value only if the selected operation modifies that flag. The write strobes `res_we_o` and `acc_we_o` tell the surrounding register file which result to store in that cycle. These are plain control pins. There is no handshake and no back-pressure, because the unit accepts a new operation every cycle.

Top module: `alu8_core`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears C, V and Z.
- R2: Operation codes are AND=0, OR=1, XOR=2, ADD=3, ADDC=4, SUBD=5, SUBDC=6, SUBS=7, SUBSC=8, DEC=9, DECC=10, CMP=11, MUL=12, MULA=13.
  - ADD gives (a+b) mod 256. ADDC gives (a+b+C) mod 256.
  - For both, C becomes 1 when the true sum exceeds 255 and 0 otherwise.
  - Both outputs carry the result, and both write strobes are high.
- R3: For ADD, ADDC, SUBD, SUBDC, SUBS, SUBSC, DEC and DECC, V becomes 1 exactly when the result overflows as a two's-complement signed value.
- R4: SUBD gives (a-b) mod 256 and SUBS gives (b-a) mod 256. For both, C becomes 0 when the true difference is negative and 1 otherwise.
- R5: SUBDC gives a-b-(1-C) and SUBSC gives b-a-(1-C), both taken mod 256. For both, C becomes 0 on underflow and 1 otherwise.
- R6: DEC gives a-1 and DECC gives a-(1-C), both taken mod 256. For both, C becomes 0 on underflow and 1 otherwise.
- R7: For AND, OR and XOR, Z is updated from the result and C and V keep their values.
- R8: MUL forms the unsigned 16-bit product a*b. Bits 15:8 go to `res_o` and bits 7:0 go to `acc_o`, and all three flags are unchanged.
- R9: MULA forms the same split product with both operands read as two's-complement signed values, and all three flags are unchanged.
- R10: CMP raises neither write strobe.
  - It sets C to 0 if b>a (unsigned) and to 1 otherwise.
  - It sets Z when a equals b, and V to C AND NOT Z.
- R11: With `exec_en_i` low, both strobes stay low and no flag changes.
- R12: Codes 14 and 15 raise no strobe and change no flag.
- R13: Z is 1 exactly when the 8-bit result of an operation that updates Z is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en_i | input | 1 | Execute this cycle: commits flags and enables the strobes |
| op_i | input | 4 | Operation select, encoding listed in R2 |
| a_i | input | W (8) | First operand |
| b_i | input | W (8) | Second operand, register or immediate |
| res_o | output | W (8) | Destination result; multiply high byte |
| acc_o | output | W (8) | Accumulator value; multiply low byte |
| res_we_o | output | 1 | Destination write strobe |
| acc_we_o | output | 1 | Accumulator write strobe |
| flag_c_o | output | 1 | Registered carry / inverted borrow |
| flag_v_o | output | 1 | Registered overflow |
| flag_z_o | output | 1 | Registered zero |

## Verification
The bench builds the unit with its default width, W=8, so every byte boundary is in reach with single literal operands. These include 0x7F+1 and 0x80-1 for signed overflow, 0xFF+1 and 0-1 for carry and borrow, 0xFF*0xFF for the largest unsigned product, and 0x80*0x80 for the most negative signed operands. Each carry-consuming operation is run after a preceding operation has set C to a known value. This shows the inverted-borrow rule in both flag states, and it shows that logic and multiply operations preserve the flags they do not modify.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_ADD   = 4'd3,
    OP_ADDC  = 4'd4,
    OP_SUBD  = 4'd5,
    OP_SUBDC = 4'd6,
    OP_SUBS  = 4'd7,
    OP_SUBSC = 4'd8,
    OP_DEC   = 4'd9,
    OP_DECC  = 4'd10,
    OP_CMP   = 4'd11,
    OP_MUL   = 4'd12,
    OP_MULA  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_ARITH = 2'd2,
    CLS_MUL   = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

  typedef struct packed {
    op_cls_e cls;
    logic    cmp;
    logic    upd_c;
    logic    upd_v;
    logic    upd_z;
    logic    res_we;
    logic    acc_we;
  } op_ctl_t;

  // Per-operation decode: result class, flag update mask, write strobes.
  function automatic op_ctl_t op_ctl(alu_op_e op);
    op_ctl_t c;
    c = '{cls: CLS_NONE, cmp: 1'b0, upd_c: 1'b0, upd_v: 1'b0,
          upd_z: 1'b0, res_we: 1'b0, acc_we: 1'b0};
    case (op)
      OP_AND, OP_OR, OP_XOR: begin
        c.cls = CLS_LOGIC; c.upd_z = 1'b1;
        c.res_we = 1'b1; c.acc_we = 1'b1;
      end
      OP_ADD, OP_ADDC, OP_SUBD, OP_SUBDC, OP_SUBS, OP_SUBSC,
      OP_DEC, OP_DECC: begin
        c.cls = CLS_ARITH; c.upd_c = 1'b1; c.upd_v = 1'b1; c.upd_z = 1'b1;
        c.res_we = 1'b1; c.acc_we = 1'b1;
      end
      OP_CMP: begin
        c.cls = CLS_ARITH; c.cmp = 1'b1;
        c.upd_c = 1'b1; c.upd_v = 1'b1; c.upd_z = 1'b1;
      end
      OP_MUL, OP_MULA: begin
        c.cls = CLS_MUL; c.res_we = 1'b1; c.acc_we = 1'b1;
      end
      default: c.cls = CLS_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   y,
  output logic           c_out,
  output logic           v_out
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] minuend;
  logic [W-1:0] addend;
  logic         cy_in;
  logic [W:0]   sum;

  // One adder serves every arithmetic code. Subtraction adds the
  // inverted subtrahend; carry-in 1 means no borrow is pending.
  always_comb begin
    minuend = a;
    addend  = b;
    cy_in   = 1'b0;
    case (op)
      OP_ADD:   begin minuend = a; addend = b;     cy_in = 1'b0; end
      OP_ADDC:  begin minuend = a; addend = b;     cy_in = c_in; end
      OP_SUBD:  begin minuend = a; addend = ~b;    cy_in = 1'b1; end
      OP_SUBDC: begin minuend = a; addend = ~b;    cy_in = c_in; end
      OP_SUBS:  begin minuend = b; addend = ~a;    cy_in = 1'b1; end
      OP_SUBSC: begin minuend = b; addend = ~a;    cy_in = c_in; end
      OP_DEC:   begin minuend = a; addend = ~ONE;  cy_in = 1'b1; end
      OP_DECC:  begin minuend = a; addend = '1;    cy_in = c_in; end
      OP_CMP:   begin minuend = a; addend = ~b;    cy_in = 1'b1; end
      default:  begin minuend = a; addend = b;     cy_in = 1'b0; end
    endcase
    sum   = {1'b0, minuend} + {1'b0, addend} + {{W{1'b0}}, cy_in};
    y     = sum[W-1:0];
    c_out = sum[W];
    v_out = (minuend[MSB] == addend[MSB]) && (sum[MSB] != minuend[MSB]);
  end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic             signed_mode,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   prod
);

  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  // Extending to the full product width makes one modular multiplier
  // give the correct low PW bits in both modes.
  always_comb begin
    a_ext = signed_mode ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    b_ext = signed_mode ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           exec_en_i,
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   acc_o,
  output logic           res_we_o,
  output logic           acc_we_o,
  output logic           flag_c_o,
  output logic           flag_v_o,
  output logic           flag_z_o
);

  localparam int PW = 2 * W;

  alu_op_e    op;
  op_ctl_t    ctl;
  alu_flags_t flags_q;
  alu_flags_t flags_d;

  logic [W-1:0]  lg_y;
  logic [W-1:0]  as_y;
  logic          as_c;
  logic          as_v;
  logic [PW-1:0] prod;
  logic [W-1:0]  z_src;
  logic          z_new;
  logic          v_new;

  assign op  = alu_op_e'(op_i);
  assign ctl = op_ctl(op);

  alu8_logic #(.W(W)) u_logic (
    .op (op),
    .a  (a_i),
    .b  (b_i),
    .y  (lg_y)
  );

  alu8_addsub #(.W(W)) u_addsub (
    .op    (op),
    .a     (a_i),
    .b     (b_i),
    .c_in  (flags_q.c),
    .y     (as_y),
    .c_out (as_c),
    .v_out (as_v)
  );

  alu8_mul #(.W(W)) u_mul (
    .signed_mode (op == OP_MULA),
    .a           (a_i),
    .b           (b_i),
    .prod        (prod)
  );

  // Result routing
  always_comb begin
    case (ctl.cls)
      CLS_LOGIC: begin res_o = lg_y;            acc_o = lg_y;           end
      CLS_MUL:   begin res_o = prod[PW-1:W];    acc_o = prod[W-1:0];    end
      default:   begin res_o = as_y;            acc_o = as_y;           end
    endcase
    res_we_o = exec_en_i & ctl.res_we;
    acc_we_o = exec_en_i & ctl.acc_we;
  end

  // Next flag values under the per-operation update mask
  always_comb begin
    z_src     = (ctl.cls == CLS_LOGIC) ? lg_y : as_y;
    z_new     = (z_src == '0);
    v_new     = ctl.cmp ? (as_c & ~z_new) : as_v;
    flags_d.c = ctl.upd_c ? as_c  : flags_q.c;
    flags_d.v = ctl.upd_v ? v_new : flags_q.v;
    flags_d.z = ctl.upd_z ? z_new : flags_q.z;
  end

  always_ff @(posedge clk) begin
    if (rst)            flags_q <= '0;
    else if (exec_en_i) flags_q <= flags_d;
  end

  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;
  assign flag_z_o = flags_q.z;

  // Checks on the flag register and strobes
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!flag_c_o && !flag_v_o && !flag_z_o));

  assert_add_wrap_sets_c_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && op == OP_ADD && res_o < a_i) |=> flag_c_o);

  assert_sub_borrow_clears_c_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && op == OP_SUBD && a_i < b_i) |=> !flag_c_o);

  assert_logic_keeps_cv_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && ctl.cls == CLS_LOGIC) |=> ($stable(flag_c_o) && $stable(flag_v_o)));

  assert_mul_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && ctl.cls == CLS_MUL) |=> $stable({flag_c_o, flag_v_o, flag_z_o}));

  assert_cmp_composite_v_R10: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && op == OP_CMP) |=> (flag_v_o == (flag_c_o && !flag_z_o)));

  assert_cmp_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && op == OP_CMP) |-> (!res_we_o && !acc_we_o));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !exec_en_i |=> $stable({flag_c_o, flag_v_o, flag_z_o}));

  assert_unused_code_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (exec_en_i && op_i > 4'd13) |-> (!res_we_o && !acc_we_o));

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  import alu8_pkg::*;

  localparam int  W        = 8;
  localparam time CLK_HALF = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         exec_en_i = 1'b0;
  logic [3:0]   op_i = 4'd0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] res_o, acc_o;
  logic         res_we_o, acc_we_o, flag_c_o, flag_v_o, flag_z_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [W-1:0] cap_res, cap_acc;
  logic         cap_rwe, cap_awe;

  always #(CLK_HALF) clk = ~clk;

  alu8_core #(.W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .exec_en_i (exec_en_i),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .res_o     (res_o),
    .acc_o     (acc_o),
    .res_we_o  (res_we_o),
    .acc_we_o  (acc_we_o),
    .flag_c_o  (flag_c_o),
    .flag_v_o  (flag_v_o),
    .flag_z_o  (flag_z_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, capture the combinational
  // outputs, let one rising edge commit the flags, return at the next
  // falling edge.
  task automatic do_op(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic en);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; exec_en_i = en;
    #1;
    cap_res = res_o; cap_acc = acc_o; cap_rwe = res_we_o; cap_awe = acc_we_o;
    @(negedge clk);
    exec_en_i = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic [7:0] r, input logic [7:0] acc,
                         input logic rwe, input logic awe);
    chk({tag, " res"}, {8'h0, cap_res}, {8'h0, r});
    chk({tag, " acc"}, {8'h0, cap_acc}, {8'h0, acc});
    chk({tag, " strobes"}, {14'h0, cap_rwe, cap_awe}, {14'h0, rwe, awe});
  endtask

  task automatic chk_flags(input string tag, input logic c, input logic v, input logic z);
    chk({tag, " CVZ"}, {13'h0, flag_c_o, flag_v_o, flag_z_o}, {13'h0, c, v, z});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_flags("R1 reset", 1'b0, 1'b0, 1'b0);
    chk("R11 reset strobes", {14'h0, res_we_o, acc_we_o}, 16'h0);
  endtask

  task automatic t_add();
    do_op(OP_ADD, 8'h7F, 8'h01, 1'b1);
    chk_out("R2 add 7F+01", 8'h80, 8'h80, 1'b1, 1'b1);
    chk_flags("R3 add signed ovf", 1'b0, 1'b1, 1'b0);
    do_op(OP_ADD, 8'hFF, 8'h01, 1'b1);
    chk_out("R2 add FF+01", 8'h00, 8'h00, 1'b1, 1'b1);
    chk_flags("R2 R13 add carry zero", 1'b1, 1'b0, 1'b1);
    do_op(OP_ADDC, 8'h10, 8'h20, 1'b1);
    chk_out("R2 addc C=1", 8'h31, 8'h31, 1'b1, 1'b1);
    chk_flags("R2 addc flags", 1'b0, 1'b0, 1'b0);
    do_op(OP_ADDC, 8'hFF, 8'h00, 1'b1);
    chk_out("R2 addc C=0", 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk_flags("R2 addc no carry", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sub();
    do_op(OP_SUBD, 8'h05, 8'h07, 1'b1);
    chk_out("R4 subd underflow", 8'hFE, 8'hFE, 1'b1, 1'b1);
    chk_flags("R4 subd borrow", 1'b0, 1'b0, 1'b0);
    do_op(OP_SUBS, 8'h05, 8'h07, 1'b1);
    chk_out("R4 subs reversed", 8'h02, 8'h02, 1'b1, 1'b1);
    chk_flags("R4 subs no borrow", 1'b1, 1'b0, 1'b0);
    do_op(OP_SUBD, 8'h80, 8'h01, 1'b1);
    chk_out("R3 subd 80-01", 8'h7F, 8'h7F, 1'b1, 1'b1);
    chk_flags("R3 subd signed ovf", 1'b1, 1'b1, 1'b0);
    do_op(OP_SUBS, 8'h01, 8'h01, 1'b1);
    chk_flags("R13 subs zero", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_subc();
    do_op(OP_SUBD, 8'h05, 8'h07, 1'b1);
    do_op(OP_SUBDC, 8'h10, 8'h05, 1'b1);
    chk_out("R5 subdc C=0", 8'h0A, 8'h0A, 1'b1, 1'b1);
    chk_flags("R5 subdc flags", 1'b1, 1'b0, 1'b0);
    do_op(OP_SUBDC, 8'h10, 8'h05, 1'b1);
    chk_out("R5 subdc C=1", 8'h0B, 8'h0B, 1'b1, 1'b1);
    do_op(OP_SUBD, 8'h00, 8'h01, 1'b1);
    chk_flags("R4 subd 00-01", 1'b0, 1'b0, 1'b0);
    do_op(OP_SUBSC, 8'h03, 8'h03, 1'b1);
    chk_out("R5 subsc C=0 underflow", 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk_flags("R5 subsc borrow", 1'b0, 1'b0, 1'b0);
    do_op(OP_SUBSC, 8'h02, 8'h05, 1'b1);
    chk_out("R5 subsc C=0", 8'h02, 8'h02, 1'b1, 1'b1);
    chk_flags("R5 subsc no borrow", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_dec();
    do_op(OP_DEC, 8'h00, 8'h00, 1'b1);
    chk_out("R6 dec 00", 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk_flags("R6 dec underflow", 1'b0, 1'b0, 1'b0);
    do_op(OP_DEC, 8'h01, 8'h00, 1'b1);
    chk_flags("R6 R13 dec to zero", 1'b1, 1'b0, 1'b1);
    do_op(OP_DEC, 8'h80, 8'h00, 1'b1);
    chk_out("R6 dec 80", 8'h7F, 8'h7F, 1'b1, 1'b1);
    chk_flags("R3 dec signed ovf", 1'b1, 1'b1, 1'b0);
    do_op(OP_DECC, 8'h42, 8'h00, 1'b1);
    chk_out("R6 decc C=1", 8'h42, 8'h42, 1'b1, 1'b1);
    chk_flags("R6 decc C=1 flags", 1'b1, 1'b0, 1'b0);
    do_op(OP_DEC, 8'h00, 8'h00, 1'b1);
    do_op(OP_DECC, 8'h42, 8'h00, 1'b1);
    chk_out("R6 decc C=0", 8'h41, 8'h41, 1'b1, 1'b1);
    do_op(OP_DEC, 8'h00, 8'h00, 1'b1);
    do_op(OP_DECC, 8'h00, 8'h00, 1'b1);
    chk_out("R6 decc 00 C=0", 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk_flags("R6 decc underflow", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_logic();
    do_op(OP_SUBD, 8'h80, 8'h01, 1'b1);
    do_op(OP_AND, 8'hF0, 8'h0F, 1'b1);
    chk_out("R7 and", 8'h00, 8'h00, 1'b1, 1'b1);
    chk_flags("R7 and keeps CV", 1'b1, 1'b1, 1'b1);
    do_op(OP_XOR, 8'h55, 8'hAA, 1'b1);
    chk_out("R7 xor", 8'hFF, 8'hFF, 1'b1, 1'b1);
    chk_flags("R7 xor keeps CV", 1'b1, 1'b1, 1'b0);
    do_op(OP_OR, 8'h00, 8'h00, 1'b1);
    chk_flags("R7 R13 or zero", 1'b1, 1'b1, 1'b1);
    do_op(OP_ADD, 8'h00, 8'h01, 1'b1);
    do_op(OP_OR, 8'h12, 8'h21, 1'b1);
    chk_out("R7 or", 8'h33, 8'h33, 1'b1, 1'b1);
    chk_flags("R7 or keeps clear CV", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mul();
    do_op(OP_SUBD, 8'h80, 8'h01, 1'b1);
    do_op(OP_MUL, 8'hFF, 8'hFF, 1'b1);
    chk_out("R8 mul FF*FF", 8'hFE, 8'h01, 1'b1, 1'b1);
    chk_flags("R8 mul keeps flags", 1'b1, 1'b1, 1'b0);
    do_op(OP_MUL, 8'h10, 8'h10, 1'b1);
    chk_out("R8 mul 10*10", 8'h01, 8'h00, 1'b1, 1'b1);
    do_op(OP_MULA, 8'hFF, 8'h02, 1'b1);
    chk_out("R9 mula -1*2", 8'hFF, 8'hFE, 1'b1, 1'b1);
    do_op(OP_MULA, 8'h80, 8'h80, 1'b1);
    chk_out("R9 mula -128*-128", 8'h40, 8'h00, 1'b1, 1'b1);
    do_op(OP_MULA, 8'h7F, 8'h81, 1'b1);
    chk_out("R9 mula 127*-127", 8'hC0, 8'hFF, 1'b1, 1'b1);
    chk_flags("R9 mula keeps flags", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_cmp();
    do_op(OP_CMP, 8'h05, 8'h07, 1'b1);
    chk("R10 cmp strobes", {14'h0, cap_rwe, cap_awe}, 16'h0);
    chk_flags("R10 cmp b>a", 1'b0, 1'b0, 1'b0);
    do_op(OP_CMP, 8'h07, 8'h05, 1'b1);
    chk_flags("R10 cmp a>b", 1'b1, 1'b1, 1'b0);
    do_op(OP_CMP, 8'h33, 8'h33, 1'b1);
    chk_flags("R10 cmp equal", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    do_op(OP_ADD, 8'hFF, 8'h01, 1'b0);
    chk("R11 idle strobes", {14'h0, cap_rwe, cap_awe}, 16'h0);
    chk_flags("R11 idle holds", 1'b1, 1'b0, 1'b1);
    do_op(OP_SUBD, 8'h00, 8'h05, 1'b0);
    chk_flags("R11 idle holds C", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_unused();
    do_op(4'd14, 8'h00, 8'h01, 1'b1);
    chk("R12 code 14 strobes", {14'h0, cap_rwe, cap_awe}, 16'h0);
    chk_flags("R12 code 14 flags", 1'b1, 1'b0, 1'b1);
    do_op(4'd15, 8'hFF, 8'h01, 1'b1);
    chk("R12 code 15 strobes", {14'h0, cap_rwe, cap_awe}, 16'h0);
    chk_flags("R12 code 15 flags", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_flags("R1 reset after use", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_subc();
    t_dec();
    t_logic();
    t_mul();
    t_cmp();
    t_idle();
    t_unused();
    t_reset_again();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule